// File: doc/BRIEF.md
# Per-Line Panel Control Pulse Generator

The block drives four auxiliary control strobes that some thin-film panels need once per display line: a sampling pulse, a clock-stop window, a power-save window and a polarity-reversal strobe. Each strobe has its own programmed pair of positions, a start and an end, that are compared against the running horizontal pixel count of the line timing generator. The strobe is asserted while the count lies in that window. The main sync and data-enable timing live elsewhere and supply the count, the line-start marker and the line total.

An end position may be set beyond the line total. The window then runs to the end of the line and carries on into the next line until the count reaches the end minus the total. Programming the end as start plus total gives a strobe that lasts one full line and crosses the line boundary. Writes land in a pending copy that is taken over only at a line start, so a strobe never glitches in the middle of a line. A per-strobe polarity bit picks the active level, and every strobe sits at its inactive level while the timing generator is disabled.

Top module: `line_pulse_gen`

## Requirements
- R1: A write with `wr_en_i` high sets the pending window of the strobe picked by `wr_sel_i` (0 sampling, 1 clock-stop, 2 power-save, 3 reversal); `wr_data_i[2*POS_W-1:POS_W]` is the start and `wr_data_i[POS_W-1:0]` is the end.
- R2: When end is not above the line total, a strobe is asserted for counts with start <= count < end; the output reflects the count seen at a clock edge from that edge on.
- R3: Start s with end s+1 gives a strobe asserted for exactly the one count s.
- R4: When end exceeds the line total, the strobe is asserted for count >= start and also for count < end - total, so the window crosses into the next line.
- R5: With `active_high_i[i]` at 1 an asserted strobe drives 1 and an idle one 0; with it at 0 the levels are swapped.
- R6: While `en_i` is low, every strobe is held at its inactive level from the next clock on.
- R7: A pending window takes effect only in a cycle with `line_start_i` high (that cycle already uses it); until then the previous window stays in force.
- R8: After reset every window is start 0, end 0, which never asserts, so all strobes show their inactive level.
- R9: Writing one strobe's window leaves the other strobes' windows unchanged.
- R10: A level-style window with start 0 and end equal to the total minus a margin is asserted from count 0 up to end-1 and idle for the remaining margin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Line timing generator enabled |
| hcnt_i | input | POS_W | Horizontal pixel count within the line |
| line_start_i | input | 1 | First count of a line; takes over pending windows |
| htotal_i | input | POS_W | Line total in clocks |
| wr_en_i | input | 1 | Window write strobe |
| wr_sel_i | input | 2 | Strobe selected for the write |
| wr_data_i | input | 2*POS_W | Start (upper half) and end (lower half) |
| active_high_i | input | 4 | Per-strobe active level, 1 = high |
| pulse_o | output | 4 | Strobes: bit 0 sampling, 1 clock-stop, 2 power-save, 3 reversal |

## Verification
The bench builds the block with POS_W set to 10 and a line total of 100, so every position, the wrap point and the margin of the level-style window are small numbers whose expected levels are easy to derive by hand. That width still leaves room for end values up to twice the total, which brings the full-line and cross-boundary windows within reach, along with the exact edges at start, end-1, end and end minus total.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
  localparam int unsigned NCH   = 4;
  localparam int unsigned SEL_W = $clog2(NCH);

  typedef enum logic [SEL_W-1:0] {
    CH_SAMPLE  = 2'd0,
    CH_CLKSTOP = 2'd1,
    CH_PWRSAVE = 2'd2,
    CH_REVERSE = 2'd3
  } chan_e;
endpackage

// File: rtl/lcp_regs.sv
module lcp_regs
  import lcp_pkg::*;
#(
  parameter int unsigned POS_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [SEL_W-1:0]            wr_sel_i,
  input  logic [2*POS_W-1:0]          wr_data_i,
  input  logic                        line_start_i,
  output logic [NCH-1:0][POS_W-1:0]   eff_start_o,
  output logic [NCH-1:0][POS_W-1:0]   eff_end_o,
  output logic [NCH-1:0][POS_W-1:0]   act_start_o,
  output logic [NCH-1:0][POS_W-1:0]   act_end_o
);
  logic [NCH-1:0][POS_W-1:0] pend_start_q, pend_end_q;
  logic [NCH-1:0][POS_W-1:0] act_start_q, act_end_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_start_q[i] <= '0;
        pend_end_q[i]   <= '0;
      end else if (wr_en_i && (wr_sel_i == SEL_W'(i))) begin
        pend_start_q[i] <= wr_data_i[2*POS_W-1:POS_W];
        pend_end_q[i]   <= wr_data_i[POS_W-1:0];
      end
    end

    // take over only at line start so a line never changes mid-way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_start_q[i] <= '0;
        act_end_q[i]   <= '0;
      end else if (line_start_i) begin
        act_start_q[i] <= pend_start_q[i];
        act_end_q[i]   <= pend_end_q[i];
      end
    end

    assign eff_start_o[i] = line_start_i ? pend_start_q[i] : act_start_q[i];
    assign eff_end_o[i]   = line_start_i ? pend_end_q[i]   : act_end_q[i];

    AST_HOLD_MID_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line_start_i |=> ($stable(act_start_q[i]) && $stable(act_end_q[i]))); // R7

    AST_OTHER_UNTOUCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_sel_i != SEL_W'(i)) |=> ($stable(pend_start_q[i]) && $stable(pend_end_q[i]))); // R9
  end

  assign act_start_o = act_start_q;
  assign act_end_o   = act_end_q;
endmodule

// File: rtl/lcp_window.sv
module lcp_window #(
  parameter int unsigned POS_W = 16
) (
  input  logic [POS_W-1:0] cnt_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] end_i,
  input  logic [POS_W-1:0] total_i,
  output logic             hit_o
);
  logic [POS_W:0]   diff;
  logic             wrap;
  logic [POS_W-1:0] carry_end;

  always_comb begin
    diff      = {1'b0, end_i} - {1'b0, total_i};
    wrap      = end_i > total_i;
    carry_end = diff[POS_W-1:0];
    if (wrap) hit_o = (cnt_i >= start_i) || (cnt_i < carry_end);
    else      hit_o = (cnt_i >= start_i) && (cnt_i < end_i);
  end
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen
  import lcp_pkg::*;
#(
  parameter int unsigned POS_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [POS_W-1:0]   hcnt_i,
  input  logic               line_start_i,
  input  logic [POS_W-1:0]   htotal_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [2*POS_W-1:0] wr_data_i,
  input  logic [3:0]         active_high_i,
  output logic [3:0]         pulse_o
);
  logic [NCH-1:0][POS_W-1:0] eff_start, eff_end, act_start, act_end;
  logic [NCH-1:0]            hit, hit_q;

  lcp_regs #(.POS_W(POS_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .line_start_i (line_start_i),
    .eff_start_o  (eff_start),
    .eff_end_o    (eff_end),
    .act_start_o  (act_start),
    .act_end_o    (act_end)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_win
    lcp_window #(.POS_W(POS_W)) i_win (
      .cnt_i   (hcnt_i),
      .start_i (eff_start[i]),
      .end_i   (eff_end[i]),
      .total_i (htotal_i),
      .hit_o   (hit[i])
    );

    AST_NO_HIT_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!line_start_i && act_end[i] <= htotal_i && hcnt_i >= act_end[i]) |=> !hit_q[i]); // R2

    AST_NO_HIT_BEFORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!line_start_i && act_end[i] <= htotal_i && hcnt_i < act_start[i]) |=> !hit_q[i]); // R2
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hit_q <= '0;
    else if (!en_i) hit_q <= '0;
    else            hit_q <= hit;
  end

  assign pulse_o = ~(hit_q ^ active_high_i);

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (hit_q == '0)); // R6

  AST_ZERO_WINDOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_start_i && act_start[0] == '0 && act_end[0] == '0) |=> !hit_q[0]); // R8
endmodule

// File: tb/test_line_pulse_gen.sv
module test_line_pulse_gen;
  localparam int unsigned W = 10;
  localparam int unsigned TOT = 100;

  typedef struct packed {
    logic [1:0]   ch;
    logic [W-1:0] s;
    logic [W-1:0] e;
    logic [W-1:0] c;
    logic         pol;
    logic         exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 10'd10, 10'd11,  10'd10, 1'b1, 1'b1},  // R3
    '{2'd0, 10'd10, 10'd11,  10'd11, 1'b1, 1'b0},  // R3
    '{2'd0, 10'd10, 10'd11,  10'd9,  1'b1, 1'b0},  // R3
    '{2'd1, 10'd0,  10'd60,  10'd0,  1'b1, 1'b1},  // R10
    '{2'd1, 10'd0,  10'd60,  10'd59, 1'b1, 1'b1},  // R10
    '{2'd1, 10'd0,  10'd60,  10'd60, 1'b1, 1'b0},  // R10
    '{2'd1, 10'd0,  10'd60,  10'd99, 1'b1, 1'b0},  // R10
    '{2'd2, 10'd80, 10'd150, 10'd49, 1'b1, 1'b1},  // R4
    '{2'd2, 10'd80, 10'd150, 10'd50, 1'b1, 1'b0},  // R4
    '{2'd2, 10'd80, 10'd150, 10'd79, 1'b1, 1'b0},  // R4
    '{2'd2, 10'd80, 10'd150, 10'd80, 1'b1, 1'b1},  // R4
    '{2'd2, 10'd80, 10'd150, 10'd99, 1'b1, 1'b1},  // R4
    '{2'd2, 10'd80, 10'd180, 10'd79, 1'b1, 1'b1},  // R4 full line
    '{2'd3, 10'd20, 10'd30,  10'd25, 1'b0, 1'b0},  // R5
    '{2'd3, 10'd20, 10'd30,  10'd30, 1'b0, 1'b1},  // R5
    '{2'd3, 10'd90, 10'd100, 10'd99, 1'b1, 1'b1},  // R2
    '{2'd3, 10'd90, 10'd100, 10'd0,  1'b1, 1'b0},  // R2
    '{2'd0, 10'd30, 10'd70,  10'd31, 1'b1, 1'b1}   // R1 R2
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [W-1:0]   hcnt = '0;
  logic           line_start = 1'b0;
  logic [W-1:0]   htotal = W'(TOT);
  logic           wr_en = 1'b0;
  logic [1:0]     wr_sel = '0;
  logic [2*W-1:0] wr_data = '0;
  logic [3:0]     pol = 4'b1111;
  logic [3:0]     pulse;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  line_pulse_gen #(.POS_W(W)) i_line_pulse_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hcnt_i(hcnt),
    .line_start_i(line_start), .htotal_i(htotal), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .active_high_i(pol),
    .pulse_o(pulse)
  );

  task automatic check(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic prog(input logic [1:0] ch, input logic [W-1:0] s, input logic [W-1:0] e);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = ch; wr_data = {s, e};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic new_line(input logic [W-1:0] c);
    @(negedge clk);
    line_start = 1'b1; hcnt = c;
    @(negedge clk);
    line_start = 1'b0;
  endtask

  task automatic hold(input logic [W-1:0] c);
    @(negedge clk);
    hcnt = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    // R8: reset windows never assert
    hold(10'd0);
    for (int i = 0; i < 4; i++) check("R8 reset idle high-pol", pulse[i], 1'b0);
    new_line(10'd5);
    for (int i = 0; i < 4; i++) check("R8 reset idle after line", pulse[i], 1'b0);
    pol = 4'b0000;
    #1;
    for (int i = 0; i < 4; i++) check("R8 R5 reset idle low-pol", pulse[i], 1'b1);
    pol = 4'b1111;

    // table walk
    for (int k = 0; k < NV; k++) begin
      pol[VECS[k].ch] = VECS[k].pol;
      prog(VECS[k].ch, VECS[k].s, VECS[k].e);
      new_line(VECS[k].c);
      check($sformatf("R1 R2 vec %0d", k), pulse[VECS[k].ch], VECS[k].exp);
      hold(VECS[k].c);
      check($sformatf("R2 vec %0d steady", k), pulse[VECS[k].ch], VECS[k].exp);
    end
    pol = 4'b1111;

    // R7: pending write waits for line start
    prog(2'd0, 10'd0, 10'd10);
    new_line(10'd50);
    check("R7 old window idle", pulse[0], 1'b0);
    prog(2'd0, 10'd0, 10'd100);
    hold(10'd50);
    check("R7 no effect mid-line", pulse[0], 1'b0);
    hold(10'd51);
    check("R7 still old window", pulse[0], 1'b0);
    new_line(10'd50);
    check("R7 applied at line start", pulse[0], 1'b1);

    // R9: other channels keep their windows
    prog(2'd1, 10'd40, 10'd60);
    prog(2'd2, 10'd0,  10'd20);
    prog(2'd3, 10'd45, 10'd55);
    new_line(10'd50);
    check("R9 ch1 set", pulse[1], 1'b1);
    check("R9 ch2 set", pulse[2], 1'b0);
    check("R9 ch3 set", pulse[3], 1'b1);
    prog(2'd2, 10'd0, 10'd100);
    new_line(10'd50);
    check("R9 ch0 kept", pulse[0], 1'b1);
    check("R9 ch1 kept", pulse[1], 1'b1);
    check("R9 ch2 rewritten", pulse[2], 1'b1);
    check("R9 ch3 kept", pulse[3], 1'b1);

    // R6: disable forces inactive levels
    pol = 4'b0101;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R6 ch0 off", pulse[0], 1'b0);
    check("R6 ch1 off", pulse[1], 1'b1);
    check("R6 ch2 off", pulse[2], 1'b0);
    check("R6 ch3 off", pulse[3], 1'b1);
    en = 1'b1;
    @(negedge clk);
    check("R6 R5 ch0 back", pulse[0], 1'b1);
    check("R6 R5 ch1 back", pulse[1], 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule